// File: doc/BRIEF.md
# Forward-Difference Shading Section

This block is one section of a systolic scan-line shader. A section owns five consecutive pixel positions on the line, starting at a base index fixed by a parameter. Every cycle it may accept one shading instruction. The instruction carries two inclusive interval endpoints, a starting intensity, the intensity's first and second forward differences, and an order selector. The order selector picks flat, linear or quadratic shading.

The five processing elements (PEs) form a purely combinational chain. PE k sees the intensity after k forward-difference steps. If its pixel index falls inside the interval, it stores the top eight bits of that intensity in its pixel register. The section registers the values after all five steps and presents them on its output port. The next section uses those values as its starting point.

The interval test is done in two parts. A coarse test compares the endpoints against the section's first and last index. Small per-PE tests then compare 3-bit local offsets.

Top module: `fd_shade_section`

## Requirements
- R1: While reset is asserted, and directly after it, every pixel register, out_valid, out_i, out_di and out_ddi read zero.
- R2: Each PE step computes I' = I + (DI << 10) modulo 2^28 and DI' = DI + DDI modulo 2^18. DDI does not change along the chain. DI is therefore aligned with the top 18 bits of I.
- R3: Order code 0 clears both DI and DDI before the chain. Code 1 clears DDI only. Codes 2 and 3 use all three values as given.
- R4: When in_valid is high and the pixel index SEC_BASE + k satisfies A <= index <= B, PE k stores bits [27:20] of its intensity in its pixel register. Its intensity is the value after k steps. The register appears at pix[8k+7:8k].
- R5: A PE whose index is outside [A,B] keeps its pixel register. It still passes updated values down the chain, so later PEs and the outputs are correct.
- R6: The interval is inclusive at both ends. It may start before the section, end after it, or cover it fully. If A > B, no pixel changes.
- R7: One cycle after an instruction is accepted, out_valid is high. At the same time out_i, out_di and out_ddi hold the values after five steps.
- R8: While in_valid is low, the pixel registers and out_i, out_di and out_ddi hold their values, and out_valid is low on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | An instruction is present this cycle |
| in_a | input | 10 | First pixel index of the interval |
| in_b | input | 10 | Last pixel index of the interval |
| in_i | input | 28 | Starting intensity |
| in_di | input | 18 | First difference |
| in_ddi | input | 18 | Second difference |
| in_order | input | 2 | 0 flat, 1 linear, 2 or 3 quadratic |
| out_valid | output | 1 | Registered outputs belong to the previous instruction |
| out_i | output | 28 | Intensity after five steps |
| out_di | output | 18 | First difference after five steps |
| out_ddi | output | 18 | Second difference passed on |
| pix | output | 40 | Five 8-bit pixel registers, PE 0 in the low byte |

## Verification
The embedded properties check the following on every cycle:
- out_valid follows in_valid by one cycle.
- The pixels and outputs freeze while in_valid is low.
- An empty interval leaves the pixels untouched.
- The flat and linear orders produce the expected outputs.
- The closed form DI + 5*DDI matches the chained first difference.

The bench's scenarios are needed to show the rest. One part is which PEs fall inside each interval: the bench sweeps every endpoint pair across the section border. The other part is the exact intensity each PE writes, including wrap-around at both word widths.

// File: rtl/fd_shade_section.sv
module fd_shade_section #(
  parameter int IDX_W    = 10,
  parameter int I_W      = 28,
  parameter int D_W      = 18,
  parameter int PIX_W    = 8,
  parameter int PE_N     = 5,
  parameter int SEC_BASE = 500
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic [IDX_W-1:0]        in_a,
  input  logic [IDX_W-1:0]        in_b,
  input  logic [I_W-1:0]          in_i,
  input  logic [D_W-1:0]          in_di,
  input  logic [D_W-1:0]          in_ddi,
  input  logic [1:0]              in_order,
  output logic                    out_valid,
  output logic [I_W-1:0]          out_i,
  output logic [D_W-1:0]          out_di,
  output logic [D_W-1:0]          out_ddi,
  output logic [PE_N*PIX_W-1:0]   pix
);
  localparam int SH    = I_W - D_W;
  localparam int POS_W = (PE_N > 1) ? $clog2(PE_N) : 1;
  localparam int CMP_W = IDX_W + 2;
  localparam logic [CMP_W-1:0] LO = CMP_W'(SEC_BASE);
  localparam logic [CMP_W-1:0] HI = CMP_W'(SEC_BASE + PE_N - 1);

  logic [D_W-1:0] di0, ddi0;
  assign di0  = (in_order == 2'd0) ? '0 : in_di;
  assign ddi0 = (in_order[1] == 1'b0) ? '0 : in_ddi;

  logic [I_W-1:0] ci [PE_N+1];
  logic [D_W-1:0] cd [PE_N+1];
  assign ci[0] = in_i;
  assign cd[0] = di0;

  for (genvar k = 0; k < PE_N; k++) begin : g_pe
    assign ci[k+1] = ci[k] + {cd[k], {SH{1'b0}}};
    assign cd[k+1] = cd[k] + ddi0;
  end

  logic [CMP_W:0] a_lo, a_hi, b_lo, b_hi;
  assign a_lo = {1'b0, CMP_W'(in_a)} - {1'b0, LO};
  assign a_hi = {1'b0, HI} - {1'b0, CMP_W'(in_a)};
  assign b_lo = {1'b0, CMP_W'(in_b)} - {1'b0, LO};
  assign b_hi = {1'b0, HI} - {1'b0, CMP_W'(in_b)};

  logic sec_hit;
  logic [POS_W-1:0] a_off, b_off;
  assign sec_hit = !a_hi[CMP_W] && !b_lo[CMP_W];
  assign a_off   = a_lo[CMP_W] ? '0 : a_lo[POS_W-1:0];
  assign b_off   = b_hi[CMP_W] ? POS_W'(PE_N - 1) : b_lo[POS_W-1:0];

  logic [PE_N-1:0] member;
  always_comb begin
    for (int k = 0; k < PE_N; k++)
      member[k] = sec_hit && (POS_W'(k) >= a_off) && (POS_W'(k) <= b_off);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pix <= '0;
    end else if (in_valid) begin
      for (int k = 0; k < PE_N; k++)
        if (member[k]) pix[k*PIX_W +: PIX_W] <= ci[k][I_W-1 -: PIX_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_i     <= '0;
      out_di    <= '0;
      out_ddi   <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_i   <= ci[PE_N];
        out_di  <= cd[PE_N];
        out_ddi <= ddi0;
      end
    end
  end

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid); // R7
  AST_IDLE_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(pix) && $stable(out_i) && $stable(out_di))); // R8
  AST_EMPTY_SPAN: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_a > in_b) |=> $stable(pix)); // R6
  AST_FLAT_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_order == 2'd0) |=> (out_i == $past(in_i) && out_di == '0 && out_ddi == '0)); // R3
  AST_LINEAR_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_order == 2'd1) |=> (out_di == $past(in_di) && out_ddi == '0)); // R3
  AST_DI_CLOSED_FORM: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_order[1]) |=>
      (out_di == D_W'($past(in_di) + D_W'(PE_N) * $past(in_ddi)) && out_ddi == $past(in_ddi))); // R2
endmodule

// File: tb/fd_shade_section_tb.sv
module fd_shade_section_tb;
  localparam int CLK_PERIOD = 10;
  localparam int BASE = 500;
  localparam int NPE  = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [9:0] in_a = '0, in_b = '0;
  logic [27:0] in_i = '0;
  logic [17:0] in_di = '0, in_ddi = '0;
  logic [1:0] in_order = '0;
  logic out_valid;
  logic [27:0] out_i;
  logic [17:0] out_di, out_ddi;
  logic [39:0] pix;

  int n_chk = 0, n_fail = 0;
  logic [7:0] ep [NPE];

  always #(CLK_PERIOD/2) clk = ~clk;

  fd_shade_section #(.IDX_W(10), .I_W(28), .D_W(18), .PIX_W(8), .PE_N(NPE), .SEC_BASE(BASE)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_a(in_a), .in_b(in_b),
    .in_i(in_i), .in_di(in_di), .in_ddi(in_ddi), .in_order(in_order),
    .out_valid(out_valid), .out_i(out_i), .out_di(out_di), .out_ddi(out_ddi), .pix(pix));

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [39:0] pack_ep();
    logic [39:0] v;
    for (int k = 0; k < NPE; k++) v[k*8 +: 8] = ep[k];
    return v;
  endfunction

  task automatic send(input int a, input int b, input logic [27:0] i0, input logic [17:0] d0,
                      input logic [17:0] dd0, input logic [1:0] ord, input string req);
    logic [27:0] mi;
    logic [17:0] md, mdd;
    in_a = 10'(a); in_b = 10'(b); in_i = i0; in_di = d0; in_ddi = dd0; in_order = ord;
    in_valid = 1'b1;
    mi = i0;
    md = (ord == 2'd0) ? 18'd0 : d0;
    mdd = (ord >= 2'd2) ? dd0 : 18'd0;
    for (int k = 0; k < NPE; k++) begin
      if (a <= BASE + k && BASE + k <= b) ep[k] = mi[27:20];
      mi = mi + {md, 10'd0};
      md = md + mdd;
    end
    @(negedge clk);
    in_valid = 1'b0;
    chk(pix == pack_ep(), req, 64'(pix), 64'(pack_ep()));
    chk(out_valid && out_i == mi && out_di == md && out_ddi == mdd, "R2/R7 outputs",
        {out_i, out_di, 18'(out_valid)}, {mi, md, 18'd1});
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
    $finish;
  end

  initial begin
    for (int k = 0; k < NPE; k++) ep[k] = 8'd0;
    repeat (3) @(negedge clk);
    chk(pix == 40'd0 && !out_valid && out_i == 0 && out_di == 0 && out_ddi == 0, "R1 reset",
        64'(pix), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(pix == 40'd0 && !out_valid, "R1 after release", 64'(pix), 64'd0);

    // R4 R5 R6: sweep every endpoint pair around the section
    begin
      int n = 1;
      for (int a = BASE - 3; a <= BASE + NPE + 2; a++)
        for (int b = BASE - 3; b <= BASE + NPE + 2; b++) begin
          send(a, b, 28'(n * 7) << 20, 18'd1 << 10, 18'd0, 2'd2, "R4/R5/R6 interval");
          n++;
        end
    end

    // R3 order selection, R2 arithmetic with signs and wrap
    send(BASE, BASE + 4, 28'h1234567, 18'h3FFFF, 18'h00123, 2'd0, "R3 flat");
    send(BASE, BASE + 4, 28'h0800000, 18'h01000, 18'h00F00, 2'd1, "R3 linear");
    send(BASE, BASE + 4, 28'h0100000, 18'h00400, 18'h00800, 2'd2, "R3 quadratic");
    send(BASE, BASE + 4, 28'h0100000, 18'h00400, 18'h00800, 2'd3, "R3 code3");
    send(BASE, BASE + 4, 28'hFF00000, 18'h20000, 18'h3FF00, 2'd2, "R2 negative wrap");
    send(BASE, BASE + 4, 28'h0000000, 18'h3FC00, 18'h3FFFF, 2'd2, "R2 descending");
    send(0, 1023, 28'hFFFFFFF, 18'h1FFFF, 18'h1FFFF, 2'd2, "R2 wrap both");
    send(BASE + 2, BASE + 2, 28'h5A00000, 18'h0AAAA, 18'h05555, 2'd2, "R5 single");
    send(BASE + 3, BASE + 1, 28'h0F00000, 18'h00400, 18'h0, 2'd2, "R6 reversed");

    // R8: inputs toggle while in_valid is low
    begin
      logic [39:0] p0;
      logic [27:0] i0;
      p0 = pix; i0 = out_i;
      in_a = 10'(BASE); in_b = 10'(BASE + 4); in_i = 28'hABCDEF0; in_di = 18'h12345; in_order = 2'd2;
      repeat (3) @(negedge clk);
      chk(pix == p0, "R8 pixels hold", 64'(pix), 64'(p0));
      chk(!out_valid && out_i == i0, "R8 outputs hold", {out_i, 1'b0, out_valid}, {i0, 2'b00});
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule